// File: doc/BRIEF.md
# Counter Array Hex Dumper

This block turns a bank of counters into one line of readable text for a serial console. When it receives a start pulse, it reads the counters one at a time through a read-address port. It captures each value and emits it as fixed-width uppercase hexadecimal characters. Values are joined with underscores, and the line ends with carriage return and line feed.

Every character leaves the block through a valid/ready byte handshake toward a UART transmitter. The transmitter may stall for any number of cycles. The block holds the pending character until the transmitter accepts it, and it raises a one-cycle completion pulse once the final character has gone.

The counter count, the counter width, the separator character and the letter case are parameters. The defaults are 32 counters of 16 bits, an underscore separator and uppercase letters.

Top module: `hex_line_dumper`

## Requirements
- R1: During and after reset, `tx_valid_o`, `busy_o` and `done_o` are low.
- R2: A `start_i` pulse seen while idle begins a line, and `busy_o` is high in the following cycle.
- R3: A line holds the 32 counters in ascending index order (0 first), separated by 0x5F (`_`), with no separator after the last value. It ends with 0x0D then 0x0A, for 161 bytes in total.
- R4: Each 16-bit value is printed as exactly 4 characters, most significant nibble first. Nibbles 0-9 map to 0x30-0x39 and nibbles A-F map to 0x41-0x46.
- R5: A byte is consumed only on a cycle with `tx_valid_o` and `tx_ready_i` both high. While valid is high and ready is low, valid stays high and `tx_byte_o` stays unchanged.
- R6: `done_o` is high for exactly one cycle: the cycle after the one in which the 0x0A byte is accepted.
- R7: A `start_i` pulse that arrives while a line is in progress is ignored. The line continues unchanged and no second line follows.
- R8: A counter is read once, in the cycle before its first character is offered. Changes to that counter's storage afterwards do not alter the characters sent for it.
- R9: A `start_i` pulse in the same cycle as `done_o` starts a new line at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to emit one line |
| rd_addr_o | output | 5 | Index of the counter being read |
| rd_data_i | input | 16 | Counter value at `rd_addr_o`, same cycle |
| tx_byte_o | output | 8 | Character offered to the transmitter |
| tx_valid_o | output | 1 | `tx_byte_o` is valid |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |
| busy_o | output | 1 | A line is in progress |
| done_o | output | 1 | One-cycle pulse after the line ends |

## Verification
Two functions can fall in the same cycle: the completion pulse, and the acceptance of a new start request, which is legal only once the block has returned to idle. The bench waits for `done_o` and raises `start_i` in that very cycle. It then requires `busy_o` one cycle later and a second line that is correct byte for byte. A second collision, a start pulse while characters are still being handshaken, is judged by requiring an intact line and an idle block after it.

// File: rtl/hexdump_pkg.sv
package hexdump_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_LOAD  = 3'd1,
      PH_DIGIT = 3'd2,
      PH_SEP   = 3'd3,
      PH_CR    = 3'd4,
      PH_LF    = 3'd5
   } dump_phase_e;

   localparam logic [7:0] CHAR_CR = 8'h0D;
   localparam logic [7:0] CHAR_LF = 8'h0A;

endpackage

// File: rtl/hexdump_sequencer.sv
module hexdump_sequencer
   import hexdump_pkg::*;
#(
   parameter int NUM_VALUES = 32,
   parameter int DIGITS     = 4,
   localparam int IDX_W     = (NUM_VALUES > 1) ? $clog2(NUM_VALUES) : 1,
   localparam int DIG_W     = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             fire_i,
   output dump_phase_e      phase_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [DIG_W-1:0] dig_o,
   output logic             load_o,
   output logic             done_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VALUES - 1);
   localparam logic [DIG_W-1:0] LAST_DIG = DIG_W'(DIGITS - 1);

   dump_phase_e      phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [DIG_W-1:0] dig_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         dig_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_LOAD;
                  idx_q   <= '0;
               end
            end
            PH_LOAD: begin
               phase_q <= PH_DIGIT;
               dig_q   <= '0;
            end
            PH_DIGIT: begin
               if (fire_i) begin
                  if (dig_q == LAST_DIG) begin
                     phase_q <= (idx_q == LAST_IDX) ? PH_CR : PH_SEP;
                  end else begin
                     dig_q <= dig_q + DIG_W'(1);
                  end
               end
            end
            PH_SEP: begin
               if (fire_i) begin
                  idx_q   <= idx_q + IDX_W'(1);
                  phase_q <= PH_LOAD;
               end
            end
            PH_CR: begin
               if (fire_i) phase_q <= PH_LF;
            end
            PH_LF: begin
               if (fire_i) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign idx_o   = idx_q;
   assign dig_o   = dig_q;
   assign load_o  = (phase_q == PH_LOAD);
   assign done_o  = done_q;

   // R7: a start while mid-line with no handshake changes nothing
   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && phase_q != PH_LOAD && start_i && !fire_i)
      |=> ($stable(phase_q) && $stable(idx_q)));

   // R3: each accepted separator moves to the next counter index
   assert_index_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SEP && fire_i) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

   // R6: completion pulse lasts a single cycle
   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/hexdump_value_reg.sv
module hexdump_value_reg #(
   parameter int VALUE_W = 16,
   localparam int DIGITS = VALUE_W / 4,
   localparam int DIG_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [VALUE_W-1:0] value_i,
   input  logic [DIG_W-1:0]   dig_i,
   output logic [3:0]         nib_o
);

   logic [VALUE_W-1:0] value_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      value_q <= '0;
      else if (load_i) value_q <= value_i;
   end

   generate
      if (DIGITS == 1) begin : g_single
         assign nib_o = value_q[3:0];
      end else begin : g_multi
         logic [3:0]       nib_arr [DIGITS];
         logic [DIG_W-1:0] sel;
         for (genvar g = 0; g < DIGITS; g++) begin : g_split
            assign nib_arr[g] = value_q[4*g +: 4];
         end
         // digit 0 is the most significant nibble
         assign sel   = DIG_W'(DIGITS - 1) - dig_i;
         assign nib_o = nib_arr[sel];
      end
   endgenerate

endmodule

// File: rtl/hexdump_byte_mux.sv
module hexdump_byte_mux
   import hexdump_pkg::*;
#(
   parameter logic [7:0] SEP_CHAR  = 8'h5F,
   parameter bit         UPPERCASE = 1'b1
) (
   input  dump_phase_e phase_i,
   input  logic [3:0]  nib_i,
   output logic [7:0]  byte_o,
   output logic        valid_o
);

   logic [7:0] alpha_base;
   logic [7:0] hex_char;

   generate
      if (UPPERCASE) begin : g_upper
         assign alpha_base = 8'h41;
      end else begin : g_lower
         assign alpha_base = 8'h61;
      end
   endgenerate

   assign hex_char = (nib_i < 4'd10) ? (8'h30 + {4'h0, nib_i})
                                     : (alpha_base + {4'h0, nib_i} - 8'd10);

   always_comb begin
      byte_o  = 8'h00;
      valid_o = 1'b1;
      case (phase_i)
         PH_DIGIT: byte_o = hex_char;
         PH_SEP:   byte_o = SEP_CHAR;
         PH_CR:    byte_o = CHAR_CR;
         PH_LF:    byte_o = CHAR_LF;
         default:  valid_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/hex_line_dumper.sv
module hex_line_dumper
   import hexdump_pkg::*;
#(
   parameter int         NUM_VALUES = 32,
   parameter int         VALUE_W    = 16,
   parameter logic [7:0] SEP_CHAR   = 8'h5F,
   parameter bit         UPPERCASE  = 1'b1,
   localparam int        DIGITS     = VALUE_W / 4,
   localparam int        IDX_W      = (NUM_VALUES > 1) ? $clog2(NUM_VALUES) : 1,
   localparam int        DIG_W      = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   output logic [IDX_W-1:0]   rd_addr_o,
   input  logic [VALUE_W-1:0] rd_data_i,
   output logic [7:0]         tx_byte_o,
   output logic               tx_valid_o,
   input  logic               tx_ready_i,
   output logic               busy_o,
   output logic               done_o
);

   generate
      if (VALUE_W < 4 || (VALUE_W % 4) != 0) begin : g_bad_width
         $error("VALUE_W must be a positive multiple of 4");
      end
      if (NUM_VALUES < 1) begin : g_bad_count
         $error("NUM_VALUES must be at least 1");
      end
   endgenerate

   dump_phase_e      phase;
   logic [DIG_W-1:0] dig;
   logic             load;
   logic             fire;
   logic [3:0]       nib;

   assign fire = tx_valid_o && tx_ready_i;

   hexdump_sequencer #(
      .NUM_VALUES (NUM_VALUES),
      .DIGITS     (DIGITS)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .fire_i  (fire),
      .phase_o (phase),
      .idx_o   (rd_addr_o),
      .dig_o   (dig),
      .load_o  (load),
      .done_o  (done_o)
   );

   hexdump_value_reg #(
      .VALUE_W (VALUE_W)
   ) i_val (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .value_i (rd_data_i),
      .dig_i   (dig),
      .nib_o   (nib)
   );

   hexdump_byte_mux #(
      .SEP_CHAR  (SEP_CHAR),
      .UPPERCASE (UPPERCASE)
   ) i_mux (
      .phase_i (phase),
      .nib_i   (nib),
      .byte_o  (tx_byte_o),
      .valid_o (tx_valid_o)
   );

   assign busy_o = (phase != PH_IDLE);

   // R5: an offered byte is held until accepted
   assert_hold_until_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));

   // R6: the completion pulse follows acceptance of the line feed
   assert_done_after_lf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(fire && tx_byte_o == CHAR_LF));

   // R4: digit characters stay inside the hex alphabet
   assert_digit_charset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && phase == PH_DIGIT) |->
      ((tx_byte_o >= 8'h30 && tx_byte_o <= 8'h39) ||
       (UPPERCASE  && tx_byte_o >= 8'h41 && tx_byte_o <= 8'h46) ||
       (!UPPERCASE && tx_byte_o >= 8'h61 && tx_byte_o <= 8'h66)));

   // R1: nothing is offered or pending while idle
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !tx_valid_o);

endmodule

// File: tb/test_hex_line_dumper.sv
`timescale 1ns/1ps
module test_hex_line_dumper;

   localparam int N    = 32;
   localparam int W    = 16;
   localparam int LINE = N * (W / 4 + 1) + 1;
   // {counter seed, ready pattern}
   localparam logic [47:0] VEC [4] = '{
      48'h0000_FFFFFFFF,
      48'hFFFF_55555555,
      48'hA5C3_00F000F1,
      48'h1234_84211248
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [4:0]  rd_addr;
   logic [15:0] rd_data;
   logic [7:0]  tx_byte;
   logic        tx_valid;
   logic        tx_ready;
   logic        busy;
   logic        done;

   always #2 clk = ~clk;

   logic [15:0] mem     [N];
   logic [15:0] exp_mem [N];
   assign rd_data = mem[rd_addr];

   hex_line_dumper i_hex_line_dumper (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .rd_addr_o  (rd_addr),
      .rd_data_i  (rd_data),
      .tx_byte_o  (tx_byte),
      .tx_valid_o (tx_valid),
      .tx_ready_i (tx_ready),
      .busy_o     (busy),
      .done_o     (done)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] hexc(input int n);
      return (n < 10) ? 8'(48 + n) : 8'(55 + n);
   endfunction

   function automatic logic [7:0] exp_byte(input int j);
      int v, p;
      if (j == LINE - 2) return 8'h0D;
      if (j == LINE - 1) return 8'h0A;
      v = j / 5;
      p = j % 5;
      if (p == 4) return 8'h5F;
      return hexc(int'((exp_mem[v] >> (12 - 4 * p)) & 16'h000F));
   endfunction

   // byte sink
   logic [7:0]  got [256];
   int          cnt = 0;
   logic [31:0] rdy_pat = 32'hFFFFFFFF;
   int          ph = 0;
   bit          poke = 1'b0;
   int          lf_age = 0;
   bit          stall_prev = 1'b0;
   logic [7:0]  stall_byte = 8'h00;

   always @(negedge clk) begin
      if (!rst_n) begin
         tx_ready   = 1'b0;
         stall_prev = 1'b0;
         lf_age     = 0;
      end else begin
         bit r;
         if (stall_prev)
            check(tx_valid && tx_byte == stall_byte, "R5", "held byte",
                  int'(tx_byte), int'(stall_byte));
         if (lf_age == 2) begin
            check(!done, "R6", "done lasts one cycle", int'(done), 0);
            lf_age = 0;
         end
         if (lf_age == 1) begin
            check(done, "R6", "done after LF", int'(done), 1);
            lf_age = 2;
         end
         r = rdy_pat[ph % 32];
         ph++;
         tx_ready   = r;
         stall_prev = tx_valid && !r;
         stall_byte = tx_byte;
         if (tx_valid && r) begin
            if (cnt < 256) got[cnt] = tx_byte;
            if (tx_byte == 8'h0A) lf_age = 1;
            cnt++;
            if (poke && cnt == 2) mem[0] = ~mem[0];
         end
      end
   end

   task automatic fill(input logic [15:0] seed);
      for (int i = 0; i < N; i++) begin
         mem[i]     = seed ^ 16'(i * 4951);
         exp_mem[i] = mem[i];
      end
   endtask

   task automatic wait_done();
      int t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!done && t < 20000);
      check(done, "R6", "done seen", int'(done), 1);
   endtask

   task automatic compare_line(input string tag);
      check(cnt == LINE, "R3", {tag, " byte count"}, cnt, LINE);
      for (int j = 0; j < LINE && j < cnt; j++)
         check(got[j] == exp_byte(j), (j % 5 < 4 && j < LINE - 2) ? "R4" : "R3",
               {tag, " byte"}, int'(got[j]), int'(exp_byte(j)));
   endtask

   task automatic start_line();
      cnt   = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R2", "busy after start", int'(busy), 1);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      fill(16'h0000);
      repeat (4) @(negedge clk);
      // R1: reset state
      check(!tx_valid, "R1", "valid in reset", int'(tx_valid), 0);
      check(!busy, "R1", "busy in reset", int'(busy), 0);
      check(!done, "R1", "done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tx_valid && !busy && !done, "R1", "idle after reset",
            int'({tx_valid, busy, done}), 0);

      // vector table: counter contents and transmitter pacing
      for (int v = 0; v < 4; v++) begin
         fill(VEC[v][47:32]);
         rdy_pat = VEC[v][31:0];
         ph      = 0;
         start_line();
         wait_done();
         compare_line($sformatf("vec%0d", v));
         @(negedge clk);
      end

      // R7: start pulses while a line is in progress
      fill(16'h5A0F);
      rdy_pat = 32'h0F0F0F0F;
      ph      = 0;
      start_line();
      repeat (25) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      compare_line("R7 busy start");
      @(negedge clk);
      @(negedge clk);
      check(!busy && cnt == LINE, "R7", "no extra line", cnt, LINE);

      // R8: counter storage changes after its value was captured
      fill(16'hC0DE);
      rdy_pat = 32'h33333333;
      ph      = 0;
      poke    = 1'b1;
      start_line();
      wait_done();
      poke = 1'b0;
      compare_line("R8 capture");
      @(negedge clk);

      // R9: new start in the done cycle
      fill(16'h7E81);
      rdy_pat = 32'hFFFFFFFF;
      ph      = 0;
      start_line();
      wait_done();
      compare_line("R9 first");
      cnt   = 0;
      fill(16'hBEEF);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R9", "busy after start on done", int'(busy), 1);
      wait_done();
      compare_line("R9 second");
      repeat (3) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule